// File: doc/BRIEF.md
# Floating-Point Control/Status Register Access Unit

This block owns the 8-bit floating-point control and status register and carries out the two register-operand forms of CSR access on it: swap (read the old value, then write the new one) and set-bits (read the old value, then OR new bits in). The register can be reached through three addresses. Each address exposes a different window onto the same eight bits: the five accrued exception flags in bits [4:0], the three-bit rounding mode in bits [7:5], or the whole byte. A write through one window merges with the bits the other windows see.

An execution pipeline presents a 32-bit instruction word, the 64-bit value of the source operand and an issue strobe. The block decodes the word. One cycle later it reports whether the word was one it handles. For a handled word it also reports a destination write enable, the destination index and the old value of the addressed window, zero-extended to 64 bits. Separately, a floating-point unit may pulse a flag-accumulate input to OR newly raised exception flags into the register.

Response sequencing uses a three-state machine. IDLE means that no response is pending. HIT means that the previous cycle issued a recognised instruction. MISS means that the previous cycle issued an unrecognised word. The transitions are as follows. Any state goes to HIT on an issue of a recognised word. Any state goes to MISS on an issue of any other word. Any state goes to IDLE when there is no issue.

Top module: `fcsr_access_unit`

## Requirements
- R1: A word is recognised only when all three of these hold:
  - bits [6:0] equal 7'b1110011;
  - bits [14:12] equal 3'b001 (swap) or 3'b010 (set-bits);
  - bits [31:20] equal 12'h001 (flags), 12'h002 (rounding mode) or 12'h003 (whole register).
- R2: An issued word that is not recognised leaves the register unchanged. It gives a response with the recognised flag low and the write enable low.
- R3: The destination index is bits [11:7] of the word. The write enable is high only for a recognised word whose destination index is nonzero. The result is the register value from before the instruction, taken through the addressed window and zero-extended to 64 bits.
- R4: Address 12'h001 reads register bits [4:0]. Swap puts operand bits [4:0] into register bits [4:0] and keeps bits [7:5]. Set-bits ORs operand bits [4:0] into bits [4:0].
- R5: Address 12'h002 reads register bits [7:5], placed in result bits [2:0]. Swap puts operand bits [2:0] into register bits [7:5] and keeps bits [4:0]. Set-bits ORs operand bits [2:0] into bits [7:5].
- R6: Address 12'h003 reads all eight bits. Swap loads operand bits [7:0]. Set-bits ORs operand bits [7:0] into the register.
- R7: Every recognised instruction updates the register, including one whose destination index is zero.
- R8: After reset the register holds 8'h00, and the recognised flag and the write enable are low.
- R9: A flag-accumulate pulse ORs its five bits into register bits [4:0]. When it arrives in the same cycle as a recognised instruction, the instruction's update is applied first and the flags are ORed in on top. The instruction's result still shows the value from before both.
- R10: The recognised flag, the write enable, the index and the result all appear in the cycle after the issue strobe. The recognised flag and the write enable last exactly one cycle per issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | 64 | Source operand value |
| flag_acc_i | input | 1 | Flag-accumulate pulse from the FPU |
| flag_acc_bits_i | input | 5 | Exception flags to accumulate |
| recog_o | output | 1 | Previous issue was a handled instruction |
| rd_we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination register index |
| rd_data_o | output | 64 | Old window value, zero-extended |

## Verification
The register changes at the same clock edge that samples the issue strobe. The recognised flag, the write enable, the index and the result register at that same edge, so all of them are due one edge after the issue. The bench drives each issue on a falling edge, waits one rising edge and compares on the next falling edge, when the issue strobe is also dropped. The register has no port of its own. Its effect is therefore observed one issue later, through a set-bits read of the whole register with a zero operand, which has no effect on the register. This read-back confirms the contents after every swap, set, accumulate and rejected word.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int FCSR_W   = 8;
    localparam int FLAG_W   = 5;
    localparam int RMODE_W  = 3;
    localparam int RMODE_LSB = FLAG_W;
    localparam int IDX_W    = 5;
    localparam int ADDR_W   = 12;

    localparam logic [6:0]        OPC_SYS     = 7'b1110011;
    localparam logic [2:0]        F3_SWAP     = 3'b001;
    localparam logic [2:0]        F3_SETB     = 3'b010;
    localparam logic [ADDR_W-1:0] ADR_FLAGS   = 12'h001;
    localparam logic [ADDR_W-1:0] ADR_RMODE   = 12'h002;
    localparam logic [ADDR_W-1:0] ADR_WHOLE   = 12'h003;

    typedef enum logic [1:0] {
        VIEW_NONE  = 2'd0,
        VIEW_FLAGS = 2'd1,
        VIEW_RMODE = 2'd2,
        VIEW_WHOLE = 2'd3
    } view_e;

    typedef enum logic {
        OP_SWAP = 1'b0,
        OP_SETB = 1'b1
    } csr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } resp_state_e;

    typedef struct packed {
        logic             hit;
        view_e            view;
        csr_op_e          op;
        logic [IDX_W-1:0] rd;
    } dec_t;

endpackage

// File: rtl/fcsr_decode.sv
module fcsr_decode
    import fcsr_pkg::*;
(
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);

    logic [6:0]        opc;
    logic [2:0]        f3;
    logic [ADDR_W-1:0] adr;
    logic              opc_ok;
    logic              f3_ok;
    view_e             view;
    logic [4:0]        unused_src_idx;

    assign opc            = insn_i[6:0];
    assign f3             = insn_i[14:12];
    assign adr            = insn_i[31:20];
    assign unused_src_idx = insn_i[19:15];

    assign opc_ok = (opc == OPC_SYS);
    assign f3_ok  = (f3 == F3_SWAP) || (f3 == F3_SETB);

    always_comb begin
        unique case (adr)
            ADR_FLAGS: view = VIEW_FLAGS;
            ADR_RMODE: view = VIEW_RMODE;
            ADR_WHOLE: view = VIEW_WHOLE;
            default:   view = VIEW_NONE;
        endcase
    end

    always_comb begin
        dec_o.hit  = opc_ok && f3_ok && (view != VIEW_NONE);
        dec_o.view = dec_o.hit ? view : VIEW_NONE;
        dec_o.op   = (f3 == F3_SETB) ? OP_SETB : OP_SWAP;
        dec_o.rd   = insn_i[11:7];
    end

endmodule

// File: rtl/fcsr_file.sv
module fcsr_file
    import fcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en_i,
    input  view_e             view_i,
    input  csr_op_e           op_i,
    input  logic [FCSR_W-1:0] src_i,
    input  logic              acc_en_i,
    input  logic [FLAG_W-1:0] acc_bits_i,
    output logic [FCSR_W-1:0] win_rd_o
);

    logic [FCSR_W-1:0] fcsr_q;
    logic [FCSR_W-1:0] wmask;
    logic [FCSR_W-1:0] wdata;
    logic [FCSR_W-1:0] after_insn;
    logic [FCSR_W-1:0] fcsr_d;

    // window read, right-aligned
    always_comb begin
        unique case (view_i)
            VIEW_FLAGS: win_rd_o = {{(FCSR_W-FLAG_W){1'b0}}, fcsr_q[FLAG_W-1:0]};
            VIEW_RMODE: win_rd_o = {{(FCSR_W-RMODE_W){1'b0}}, fcsr_q[FCSR_W-1:RMODE_LSB]};
            VIEW_WHOLE: win_rd_o = fcsr_q;
            default:    win_rd_o = '0;
        endcase
    end

    // operand aligned into the addressed field
    always_comb begin
        unique case (view_i)
            VIEW_FLAGS: begin
                wmask = {{(FCSR_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}};
                wdata = {{(FCSR_W-FLAG_W){1'b0}}, src_i[FLAG_W-1:0]};
            end
            VIEW_RMODE: begin
                wmask = {{RMODE_W{1'b1}}, {RMODE_LSB{1'b0}}};
                wdata = {src_i[RMODE_W-1:0], {RMODE_LSB{1'b0}}};
            end
            VIEW_WHOLE: begin
                wmask = {FCSR_W{1'b1}};
                wdata = src_i;
            end
            default: begin
                wmask = '0;
                wdata = '0;
            end
        endcase
    end

    always_comb begin
        if (!upd_en_i) begin
            after_insn = fcsr_q;
        end else if (op_i == OP_SETB) begin
            after_insn = fcsr_q | wdata;
        end else begin
            after_insn = (fcsr_q & ~wmask) | wdata;
        end
        fcsr_d = after_insn;
        if (acc_en_i) begin
            fcsr_d[FLAG_W-1:0] = after_insn[FLAG_W-1:0] | acc_bits_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcsr_q <= '0;
        end else begin
            fcsr_q <= fcsr_d;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en_i && !acc_en_i) |=> $stable(fcsr_q)) else $error("reg moved"); // R2

    AST_ACC_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en_i |=> ((fcsr_q[FLAG_W-1:0] & $past(acc_bits_i)) == $past(acc_bits_i)))
        else $error("acc flags lost"); // R9

    AST_RMODE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && view_i == VIEW_RMODE && op_i == OP_SWAP && !acc_en_i)
        |=> (fcsr_q[FCSR_W-1:RMODE_LSB] == $past(src_i[RMODE_W-1:0]))
            && (fcsr_q[FLAG_W-1:0] == $past(fcsr_q[FLAG_W-1:0])))
        else $error("rmode swap"); // R5

endmodule

// File: rtl/fcsr_resp.sv
module fcsr_resp
    import fcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  dec_t              dec_i,
    input  logic [FCSR_W-1:0] win_rd_i,
    output logic              recog_o,
    output logic              rd_we_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic [XLEN-1:0]   rd_data_o
);

    resp_state_e state_q;
    resp_state_e state_d;
    logic             we_q;
    logic [IDX_W-1:0] idx_q;
    logic [XLEN-1:0]  data_q;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (!issue_i)         state_d = ST_IDLE;
                else if (dec_i.hit)   state_d = ST_HIT;
                else                  state_d = ST_MISS;
            end
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q   <= 1'b0;
            idx_q  <= '0;
            data_q <= '0;
        end else begin
            we_q <= issue_i && dec_i.hit && (dec_i.rd != '0);
            if (issue_i) begin
                idx_q  <= dec_i.rd;
                data_q <= dec_i.hit ? {{(XLEN-FCSR_W){1'b0}}, win_rd_i} : '0;
            end
        end
    end

    assign recog_o   = (state_q == ST_HIT);
    assign rd_we_o   = we_q;
    assign rd_idx_o  = idx_q;
    assign rd_data_o = data_q;

    AST_WE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> recog_o) else $error("we without hit"); // R3

    AST_WE_NONZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> (rd_idx_o != '0)) else $error("we to x0"); // R3

    AST_RESP_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        recog_o |-> $past(issue_i)) else $error("late response"); // R10

    AST_MISS_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MISS) |-> !rd_we_o) else $error("miss wrote"); // R2

endmodule

// File: rtl/fcsr_access_unit.sv
module fcsr_access_unit
    import fcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [31:0]       insn_i,
    input  logic [XLEN-1:0]   rs1_val_i,
    input  logic              flag_acc_i,
    input  logic [FLAG_W-1:0] flag_acc_bits_i,
    output logic              recog_o,
    output logic              rd_we_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    output logic [XLEN-1:0]   rd_data_o
);

    dec_t              dec;
    logic [FCSR_W-1:0] win_rd;
    logic              unused_rs1_hi;

    assign unused_rs1_hi = ^rs1_val_i[XLEN-1:FCSR_W];

    fcsr_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    fcsr_file u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en_i   (issue_i && dec.hit),
        .view_i     (dec.view),
        .op_i       (dec.op),
        .src_i      (rs1_val_i[FCSR_W-1:0]),
        .acc_en_i   (flag_acc_i),
        .acc_bits_i (flag_acc_bits_i),
        .win_rd_o   (win_rd)
    );

    fcsr_resp #(.XLEN(XLEN)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_i   (issue_i),
        .dec_i     (dec),
        .win_rd_i  (win_rd),
        .recog_o   (recog_o),
        .rd_we_o   (rd_we_o),
        .rd_idx_o  (rd_idx_o),
        .rd_data_o (rd_data_o)
    );

    AST_DATA_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        recog_o |-> (rd_data_o[XLEN-1:FCSR_W] == '0)) else $error("not zero-extended"); // R3

endmodule

// File: tb/fcsr_access_unit_tb_top.sv
module fcsr_access_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] rs1_val_i = '0;
    logic        flag_acc_i = 1'b0;
    logic [4:0]  flag_acc_bits_i = '0;
    logic        recog_o;
    logic        rd_we_o;
    logic [4:0]  rd_idx_o;
    logic [63:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model = 8'h00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fcsr_access_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
        .rs1_val_i(rs1_val_i), .flag_acc_i(flag_acc_i),
        .flag_acc_bits_i(flag_acc_bits_i), .recog_o(recog_o), .rd_we_o(rd_we_o),
        .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o)
    );

    function automatic logic [31:0] enc(input logic [11:0] adr, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
        return {adr, 5'd7, f3, rd, opc};
    endfunction

    function automatic logic [7:0] win(input logic [11:0] adr, input logic [7:0] v);
        case (adr)
            12'h001: return {3'b0, v[4:0]};
            12'h002: return {5'b0, v[7:5]};
            default: return v;
        endcase
    endfunction

    function automatic logic [7:0] upd(input logic [11:0] adr, input logic [2:0] f3,
                                       input logic [7:0] v, input logic [63:0] s);
        case (adr)
            12'h001: return (f3 == 3'b010) ? (v | {3'b0, s[4:0]}) : {v[7:5], s[4:0]};
            12'h002: return (f3 == 3'b010) ? (v | {s[2:0], 5'b0}) : {s[2:0], v[4:0]};
            default: return (f3 == 3'b010) ? (v | s[7:0]) : s[7:0];
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one issue; returns outputs sampled one edge later
    task automatic issue(input logic [31:0] w, input logic [63:0] s, input logic acc,
                         input logic [4:0] accb, output logic rec, output logic we,
                         output logic [4:0] idx, output logic [63:0] dat);
        @(negedge clk);
        issue_i = 1'b1; insn_i = w; rs1_val_i = s;
        flag_acc_i = acc; flag_acc_bits_i = accb;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0; flag_acc_i = 1'b0;
        rec = recog_o; we = rd_we_o; idx = rd_idx_o; dat = rd_data_o;
    endtask

    task automatic readback(input string req);
        logic r, w; logic [4:0] i; logic [63:0] d;
        issue(enc(12'h003, 3'b010, 5'd1, 7'b1110011), 64'h0, 1'b0, 5'h0, r, w, i, d);
        chk(req, d, {56'h0, model});
    endtask

    task automatic t_reset();
        chk("R8 recog", {63'h0, recog_o}, 64'h0);
        chk("R8 we", {63'h0, rd_we_o}, 64'h0);
        readback("R8 reset value");
    endtask

    task automatic t_legal();
        logic r, w; logic [4:0] i; logic [63:0] d;
        logic [63:0] pats [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hA5A5_0000_0000_00B6, 64'h49};
        foreach (pats[p]) begin
            for (int f = 1; f <= 2; f++) begin
                for (int a = 1; a <= 3; a++) begin
                    logic [4:0] rdx = 5'(3 + a + p);
                    issue(enc(12'(a), 3'(f), rdx, 7'b1110011), pats[p], 1'b0, 5'h0, r, w, i, d);
                    chk("R1 recog", {63'h0, r}, 64'h1);
                    chk("R10 we", {63'h0, w}, 64'h1);
                    chk("R3 idx", {59'h0, i}, {59'h0, rdx});
                    chk(a == 1 ? "R4 read" : (a == 2 ? "R5 read" : "R6 read"),
                        d, {56'h0, win(12'(a), model)});
                    model = upd(12'(a), 3'(f), model, pats[p]);
                    readback(a == 1 ? "R4 update" : (a == 2 ? "R5 update" : "R6 update"));
                end
            end
            // clear between patterns so set-bits has room to act
            issue(enc(12'h003, 3'b001, 5'd0, 7'b1110011), 64'h0, 1'b0, 5'h0, r, w, i, d);
            model = 8'h00;
        end
    endtask

    task automatic t_rd_zero();
        logic r, w; logic [4:0] i; logic [63:0] d;
        issue(enc(12'h003, 3'b001, 5'd0, 7'b1110011), 64'h5A, 1'b0, 5'h0, r, w, i, d);
        chk("R7 recog", {63'h0, r}, 64'h1);
        chk("R3 no write to x0", {63'h0, w}, 64'h0);
        model = 8'h5A;
        readback("R7 update with rd zero");
    endtask

    task automatic t_illegal();
        logic r, w; logic [4:0] i; logic [63:0] d;
        logic [31:0] bad [7];
        bad[0] = enc(12'h001, 3'b000, 5'd4, 7'b1110011);
        bad[1] = enc(12'h002, 3'b011, 5'd4, 7'b1110011);
        bad[2] = enc(12'h003, 3'b101, 5'd4, 7'b1110011);
        bad[3] = enc(12'h000, 3'b001, 5'd4, 7'b1110011);
        bad[4] = enc(12'h004, 3'b010, 5'd4, 7'b1110011);
        bad[5] = enc(12'h803, 3'b001, 5'd4, 7'b1110011);
        bad[6] = enc(12'h003, 3'b001, 5'd4, 7'b0110011);
        foreach (bad[k]) begin
            issue(bad[k], 64'hFF, 1'b0, 5'h0, r, w, i, d);
            chk("R1 rejected", {63'h0, r}, 64'h0);
            chk("R2 no write", {63'h0, w}, 64'h0);
            readback("R2 register untouched");
        end
    endtask

    task automatic t_accumulate();
        logic r, w; logic [4:0] i; logic [63:0] d;
        issue(enc(12'h003, 3'b001, 5'd0, 7'b1110011), 64'h00, 1'b0, 5'h0, r, w, i, d);
        model = 8'h00;
        // accumulate alone
        @(negedge clk); flag_acc_i = 1'b1; flag_acc_bits_i = 5'h05;
        @(negedge clk); flag_acc_i = 1'b0;
        model = 8'h05;
        readback("R9 accumulate alone");
        // swap of flags with accumulate in the same cycle
        issue(enc(12'h001, 3'b001, 5'd9, 7'b1110011), 64'h12, 1'b1, 5'h08, r, w, i, d);
        chk("R9 read before both", d, 64'h05);
        model = 8'h1A;
        readback("R9 insn then accumulate");
        // whole swap with accumulate
        issue(enc(12'h003, 3'b001, 5'd9, 7'b1110011), 64'hE0, 1'b1, 5'h01, r, w, i, d);
        chk("R9 read before both", d, 64'h1A);
        model = 8'hE1;
        readback("R9 whole swap then accumulate");
    endtask

    task automatic t_pulse();
        @(negedge clk);
        chk("R10 recog one cycle", {63'h0, recog_o}, 64'h0);
        chk("R10 we one cycle", {63'h0, rd_we_o}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_legal();
        t_rd_zero();
        t_illegal();
        t_accumulate();
        t_pulse();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule